// File: doc/BRIEF.md
# Asynchronous Pseudo-SRAM Host Controller

This block sits in the host clock domain and drives an external 16-bit pseudo-SRAM over its plain asynchronous, SRAM-style bus. Clients issue single-word reads and writes through a valid/ready request port. Each request carries a word address, 16 bits of write data and two byte enables. The controller turns each request into a timed strobe sequence on the chip-enable, output-enable, write-enable and per-byte lane selects. For a read, it samples the memory data bus once the access time has elapsed and returns the word on a one-cycle response strobe.

All memory timings are given in nanoseconds at elaboration and converted to whole clock cycles by rounding up. These are the power-up hold-off, the access time, the write pulse, the maximum write-enable low time, and the minimum read and write cycle times. The address-latch input stays low, so the address flows straight through. The memory clock is held at a constant level. The memory's wait output is never consulted. The address width defaults to 22 bits for the 4M-word part and may be set to 21 for the 2M-word part.

Top module: `psram_async_ctrl`

## Requirements
- R1: The active-low reset is asserted asynchronously and released through a two-stage synchronizer. From reset until `init_done` rises, `mem_ce_n` is high and `req_ready` is low. `init_done` rises exactly ceil(INIT_NS/CLK_NS)+2 clock cycles after `rst_n` deasserts. Until then no request is accepted, including one that is held valid.
- R2: A read holds `mem_ce_n` and `mem_oe_n` low for exactly ACC_CYC = ceil(ACC_NS/CLK_NS) cycles, with `mem_we_n` high. `mem_lb_n` is low if and only if `req_be[0]` was set, and it selects data bits 7:0. `mem_ub_n` is low if and only if `req_be[1]` was set, and it selects bits 15:8. The word is sampled on the last such cycle. `rsp_valid` pulses ACC_CYC cycles after acceptance. In `rsp_rdata`, the byte lanes that were not enabled read as zero.
- R3: A write holds `mem_ce_n`, `mem_we_n` and the enabled lane selects low for exactly WR_CYC = ceil(WP_NS/CLK_NS) cycles, with `mem_oe_n` high. All of these strobes return high on the same clock edge. `rsp_valid` pulses WR_CYC cycles after acceptance.
- R4: In the cycle after the write strobes rise, `mem_dq_oe` is still high, and `mem_dq_o` and `mem_addr` are unchanged.
- R5: `mem_adv_n` is always low and `mem_clk` is always low.
- R6: The level and activity of `mem_wait` change neither the timing nor the data of any access.
- R7: The write-enable low pulse never reaches TCEM_CYC cycles. An elaboration check rejects parameters where WR_CYC >= TCEM_CYC.
- R8: A request with `req_be` = 2'b00 completes with `rsp_valid` in the cycle after acceptance. `mem_ce_n` never goes low for it. A read of this kind returns zero.
- R9: `mem_dq_oe` is high only while `mem_we_n` is low and in the one cycle that follows. It is never high while `mem_oe_n` is low, and it is low in the cycle before `mem_oe_n` falls.
- R10: Between two accesses, `mem_ce_n` stays high for at least one cycle. Successive falling edges of `mem_ce_n` are at least max(TRC_CYC, TWC_CYC) cycles apart.
- R11: `req_ready` is low whenever `mem_ce_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zeroed |
| init_done | output | 1 | Power-up hold-off has elapsed |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable of the data-bus driver |
| mem_dq_i | input | 16 | Data returned by the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low byte select, active low |
| mem_ub_n | output | 1 | High byte select, active low |
| mem_adv_n | output | 1 | Address latch control, held low |
| mem_clk | output | 1 | Memory clock, held static low |
| mem_wait | input | 1 | Memory wait output, ignored |

## Verification
The hardest case to reach is the turnaround where a write is followed at once by a read. Here the bus driver must drop while the address and data are still held after the write strobes rise, and it must be low for a full cycle before output-enable falls. The stimulus table places reads directly behind writes to the same and to different words. A request is presented again at the first cycle `req_ready` allows, so every gap is at its minimum. A held-valid write issued during the power-up wait, and `mem_wait` forced high, low and toggling, cover the hold-off and the ignored wait input.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_IDLE  = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_GAP   = 3'd4
  } psram_state_e;

  // whole cycles covering a time, rounded up
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // a - b, clipped at zero
  function automatic int unsigned sub_floor(input int unsigned a, input int unsigned b);
    return (a > b) ? (a - b) : 0;
  endfunction

endpackage

// File: rtl/psram_rst_sync.sv
module psram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      sync_q  <= stage_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/psram_init_wait.sv
module psram_init_wait #(
  parameter int unsigned INIT_CYC = 15000,
  localparam int unsigned W = $clog2(INIT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);

  localparam logic [W-1:0] LIMIT = W'(INIT_CYC);

  logic [W-1:0] cnt_q;
  logic         cnt_en;

  assign cnt_en = (cnt_q != LIMIT);
  assign done   = !cnt_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/psram_phase_timer.sv
module psram_phase_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/psram_strobe_decode.sv
module psram_strobe_decode
  import psram_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  psram_state_e     st,
  input  logic [LANES-1:0] lane_en,
  input  logic             wr_tail,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic [LANES-1:0] lane_n,
  output logic             dq_oe
);

  logic active;

  assign active = (st == ST_READ) || (st == ST_WRITE);
  assign ce_n   = !active;
  assign oe_n   = (st != ST_READ);
  assign we_n   = (st != ST_WRITE);
  assign dq_oe  = (st == ST_WRITE) || wr_tail;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_n[g] = !(active && lane_en[g]);
  end

endmodule

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl
  import psram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 22,
  parameter int unsigned CLK_NS  = 10,
  parameter int unsigned INIT_NS = 150000,
  parameter int unsigned ACC_NS  = 70,
  parameter int unsigned WP_NS   = 45,
  parameter int unsigned TCEM_NS = 4000,
  parameter int unsigned TRC_NS  = 70,
  parameter int unsigned TWC_NS  = 70,
  localparam int unsigned LANES  = 2,
  localparam int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              init_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic              mem_adv_n,
  output logic              mem_clk,
  input  logic              mem_wait
);

  localparam int unsigned INIT_CYC = ns_to_cyc(INIT_NS, CLK_NS);
  localparam int unsigned ACC_CYC  = max_u(1, ns_to_cyc(ACC_NS, CLK_NS));
  localparam int unsigned WR_CYC   = max_u(1, ns_to_cyc(WP_NS, CLK_NS));
  localparam int unsigned TCEM_CYC = ns_to_cyc(TCEM_NS, CLK_NS);
  localparam int unsigned TRC_CYC  = ns_to_cyc(TRC_NS, CLK_NS);
  localparam int unsigned TWC_CYC  = ns_to_cyc(TWC_NS, CLK_NS);
  localparam int unsigned RGAP_CYC = max_u(1, sub_floor(TRC_CYC, ACC_CYC));
  localparam int unsigned WGAP_CYC = max_u(2, sub_floor(TWC_CYC, WR_CYC));
  localparam int unsigned TMR_MAX  = max_u(max_u(ACC_CYC, WR_CYC), max_u(RGAP_CYC, WGAP_CYC));
  localparam int unsigned TMR_W    = $clog2(TMR_MAX + 1);

  // R7: write pulse must stay below the maximum write-enable low time
  if (WR_CYC >= TCEM_CYC) begin : g_bad_wp
    $error("write pulse cycles must be below the write-enable low limit");
  end

  logic rst_sync_n;
  logic init_ok;
  logic tmr_exp;
  logic tmr_load;
  logic [TMR_W-1:0] tmr_val;

  psram_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdata_en;
  logic              rsp_q, rsp_d;
  logic              tail_q, tail_d;
  logic              accept;
  logic              be_none;
  logic [DATA_W-1:0] lane_mask;
  logic [LANES-1:0]  lane_n;
  logic              unused_wait;

  assign unused_wait = mem_wait;

  psram_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  psram_init_wait #(.INIT_CYC(INIT_CYC)) u_init (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .done  (init_ok)
  );

  psram_phase_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  psram_strobe_decode #(.LANES(LANES)) u_strobe (
    .st      (state_q),
    .lane_en (be_q),
    .wr_tail (tail_q),
    .ce_n    (mem_ce_n),
    .oe_n    (mem_oe_n),
    .we_n    (mem_we_n),
    .lane_n  (lane_n),
    .dq_oe   (mem_dq_oe)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign lane_mask[g*LANE_W +: LANE_W] = {LANE_W{be_q[g]}};
  end

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign be_none   = (req_be == '0);

  // next state and timer control
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_INIT: begin
        if (init_ok) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (accept && !be_none) begin
          tmr_load = 1'b1;
          if (req_write) begin
            state_d = ST_WRITE;
            tmr_val = TMR_W'(WR_CYC - 1);
          end else begin
            state_d = ST_READ;
            tmr_val = TMR_W'(ACC_CYC - 1);
          end
        end
      end
      ST_READ: begin
        if (tmr_exp) begin
          state_d  = ST_GAP;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(RGAP_CYC - 1);
        end
      end
      ST_WRITE: begin
        if (tmr_exp) begin
          state_d  = ST_GAP;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(WGAP_CYC - 1);
        end
      end
      ST_GAP: begin
        if (tmr_exp) state_d = ST_IDLE;
      end
      default: state_d = ST_INIT;
    endcase
  end

  // response and capture control
  always_comb begin
    rsp_d    = ((state_q == ST_READ) || (state_q == ST_WRITE)) && tmr_exp;
    tail_d   = (state_q == ST_WRITE) && tmr_exp;
    rdata_en = 1'b0;
    rdata_d  = mem_dq_i & lane_mask;
    if ((state_q == ST_READ) && tmr_exp) begin
      rdata_en = 1'b1;
    end else if (accept && be_none) begin
      rsp_d    = 1'b1;
      rdata_en = !req_write;
      rdata_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_INIT;
      rsp_q   <= 1'b0;
      tail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rsp_q   <= rsp_d;
      tail_q  <= tail_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept && !be_none) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign init_done = (state_q != ST_INIT) || init_ok;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;
  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign mem_lb_n  = lane_n[0];
  assign mem_ub_n  = lane_n[1];
  assign mem_adv_n = 1'b0;
  assign mem_clk   = 1'b0;

endmodule

// File: rtl/psram_async_ctrl_chk.sv
module psram_async_ctrl_chk #(
  parameter int unsigned ADDR_W   = 22,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned TCEM_CYC = 400
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_be,
  input logic              init_done,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic              mem_adv_n,
  input logic              mem_clk
);

  int unsigned we_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt <= 0;
    end else if (!mem_we_n) begin
      we_low_cnt <= we_low_cnt + 1;
    end else begin
      we_low_cnt <= 0;
    end
  end

  // R1
  init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (mem_ce_n && !req_ready));

  // R2
  read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  // R3
  write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_ce_n && mem_lb_n && mem_ub_n));

  // R3
  write_no_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  // R4
  write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_o) && $stable(mem_addr)));

  // R5
  static_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (!mem_adv_n && $stable(mem_clk)));

  // R7
  we_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (we_low_cnt < TCEM_CYC));

  // R8
  empty_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_be == 2'b00)) |=> (mem_ce_n && rsp_valid));

  // R9
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  // R9
  bus_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  // R10
  ce_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |=> mem_ce_n);

  // R11
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

endmodule

bind psram_async_ctrl psram_async_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .TCEM_CYC (TCEM_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_be    (req_be),
  .init_done (init_done),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_dq_o  (mem_dq_o),
  .mem_dq_oe (mem_dq_oe),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_lb_n  (mem_lb_n),
  .mem_ub_n  (mem_ub_n),
  .mem_adv_n (mem_adv_n),
  .mem_clk   (mem_clk)
);

// File: tb/psram_async_ctrl_tb.sv
module psram_async_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 22;
  localparam int INIT_NS    = 400;
  localparam int INIT_CYC   = 40;
  localparam int ACC_CYC    = 7;
  localparam int WR_CYC     = 5;
  localparam int TCEM_CYC   = 400;
  localparam int CYC_MIN    = 7;
  localparam logic [17:0] HI = 18'h2ABCD;

  // {wr, be[1:0], addr[4:0], wdata[15:0], expected rdata[15:0]}
  localparam int NVEC = 14;
  localparam logic [39:0] VEC [NVEC] = '{
    {1'b0, 2'b11, 5'd2,  16'h0000, 16'hC232},
    {1'b1, 2'b11, 5'd2,  16'h1234, 16'h0000},
    {1'b0, 2'b11, 5'd2,  16'h0000, 16'h1234},
    {1'b1, 2'b01, 5'd5,  16'hABCD, 16'h0000},
    {1'b0, 2'b11, 5'd5,  16'h0000, 16'hC5CD},
    {1'b1, 2'b10, 5'd5,  16'h7788, 16'h0000},
    {1'b0, 2'b10, 5'd5,  16'h0000, 16'h7700},
    {1'b0, 2'b01, 5'd5,  16'h0000, 16'h00CD},
    {1'b1, 2'b00, 5'd7,  16'hFFFF, 16'h0000},
    {1'b0, 2'b11, 5'd7,  16'h0000, 16'hC737},
    {1'b1, 2'b11, 5'd15, 16'h0F0F, 16'h0000},
    {1'b0, 2'b11, 5'd15, 16'h0000, 16'h0F0F},
    {1'b0, 2'b00, 5'd0,  16'h0000, 16'h0000},
    {1'b0, 2'b11, 5'd3,  16'h0000, 16'h5555}
  };

  logic clk;
  logic rst_n;
  logic req_valid, req_ready, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic rsp_valid;
  logic [15:0] rsp_rdata;
  logic init_done;
  logic [ADDR_W-1:0] mem_addr;
  logic [15:0] mem_dq_o, mem_dq_i;
  logic mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
  logic mem_adv_n, mem_clk, mem_wait;

  int n_chk, n_bad;
  int cyc;
  int wait_mode;
  logic [15:0] model [16];

  // monitor error counters
  int e_r1, e_r2, e_r3, e_r4, e_r5, e_r9, e_r10, e_r11;
  int ce_falls;
  int max_wlen;

  psram_async_ctrl #(
    .ADDR_W  (ADDR_W),
    .CLK_NS  (CLK_PERIOD),
    .INIT_NS (INIT_NS)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .init_done (init_done),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe),
    .mem_dq_i  (mem_dq_i),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_lb_n  (mem_lb_n),
    .mem_ub_n  (mem_ub_n),
    .mem_adv_n (mem_adv_n),
    .mem_clk   (mem_clk),
    .mem_wait  (mem_wait)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  assign mem_wait = (wait_mode == 1) ? 1'b1 :
                    (wait_mode == 2) ? 1'b0 : (cyc[0] ^ cyc[3]);

  // memory model: drives the full word while selected for reading
  assign mem_dq_i = (!mem_ce_n && !mem_oe_n) ? model[mem_addr[3:0]] : 16'hDEAD;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // protocol monitor, sampled away from the active edge
  logic prev_ce_n, prev_oe_n, prev_we_n, prev_dq_oe;
  int wlen, rlen, since_fall;
  bit seen_fall;
  logic [ADDR_W-1:0] p_addr;
  logic [15:0] p_data;
  logic p_lb_n, p_ub_n;
  logic [1:0] cur_be;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ce_n <= 1'b1; prev_oe_n <= 1'b1; prev_we_n <= 1'b1; prev_dq_oe <= 1'b0;
      wlen <= 0; rlen <= 0; since_fall <= 0; seen_fall <= 1'b0;
    end else begin
      // R5
      if (mem_adv_n !== 1'b0 || mem_clk !== 1'b0) e_r5++;
      // R1
      if (!init_done && (mem_ce_n !== 1'b1 || req_ready !== 1'b0)) e_r1++;
      // R11
      if (!mem_ce_n && req_ready) e_r11++;
      // R2 / R3 lane selects follow the request's enables
      if (!mem_ce_n && (mem_lb_n !== ~cur_be[0] || mem_ub_n !== ~cur_be[1])) e_r2++;
      // R10 start spacing
      since_fall <= since_fall + 1;
      if (prev_ce_n && !mem_ce_n) begin
        ce_falls++;
        if (seen_fall && since_fall < CYC_MIN) e_r10++;
        seen_fall <= 1'b1;
        since_fall <= 1;
      end
      // R9
      if (!mem_oe_n && mem_dq_oe) e_r9++;
      if (prev_oe_n && !mem_oe_n && prev_dq_oe) e_r9++;
      if (mem_dq_oe && mem_we_n && prev_we_n) e_r9++;
      // R2 read strobes
      if (!mem_oe_n) begin
        if (mem_ce_n || !mem_we_n) e_r2++;
        rlen <= rlen + 1;
      end else if (!prev_oe_n) begin
        if (rlen != ACC_CYC) e_r2++;
        rlen <= 0;
      end
      // R3 / R4 write strobes and hold
      if (!mem_we_n) begin
        if (mem_ce_n || !mem_oe_n) e_r3++;
        wlen <= wlen + 1;
        p_addr <= mem_addr; p_data <= mem_dq_o; p_lb_n <= mem_lb_n; p_ub_n <= mem_ub_n;
      end else if (!prev_we_n) begin
        if (wlen != WR_CYC) e_r3++;
        if (wlen > max_wlen) max_wlen = wlen;
        if (!mem_ce_n || !mem_lb_n || !mem_ub_n) e_r3++;
        if (!mem_dq_oe || mem_dq_o !== p_data || mem_addr !== p_addr) e_r4++;
        if (!p_lb_n) model[p_addr[3:0]][7:0]  = p_data[7:0];
        if (!p_ub_n) model[p_addr[3:0]][15:8] = p_data[15:8];
        wlen <= 0;
      end
      prev_ce_n <= mem_ce_n; prev_oe_n <= mem_oe_n;
      prev_we_n <= mem_we_n; prev_dq_oe <= mem_dq_oe;
    end
  end

  task automatic do_req(input logic wr, input logic [1:0] be, input logic [3:0] a,
                        input logic [15:0] wd, input logic [15:0] exp, input string tag);
    int lat;
    int falls0;
    int exp_lat;
    req_write = wr; req_be = be; req_addr = {HI, a}; req_wdata = wd; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    cur_be = be;
    falls0 = ce_falls;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    exp_lat = (be == 2'b00) ? 0 : (wr ? WR_CYC : ACC_CYC);
    chk(lat == exp_lat, {tag, " latency (R2 R3 R8)"}, lat, exp_lat);
    if (!wr) chk(rsp_rdata === exp, {tag, " rdata (R2)"}, rsp_rdata, exp);
    if (be == 2'b00) chk(ce_falls == falls0, {tag, " no chip enable (R8)"}, ce_falls - falls0, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = {4'hC, 4'(i), 4'h3, 4'(i)};
    n_chk = 0; n_bad = 0; cyc = 0; wait_mode = 0; max_wlen = 0;
    e_r1 = 0; e_r2 = 0; e_r3 = 0; e_r4 = 0; e_r5 = 0; e_r9 = 0; e_r10 = 0; e_r11 = 0;
    ce_falls = 0; cur_be = 2'b11;
    rst_n = 1'b0;
    // a write held valid across the whole power-up wait
    req_valid = 1'b1; req_write = 1'b1; req_be = 2'b11;
    req_addr = {HI, 4'd3}; req_wdata = 16'h5555;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_ce_n === 1'b1 && req_ready === 1'b0, "reset strobes/ready (R1)", {mem_ce_n, req_ready}, 2'b10);
    chk(init_done === 1'b0 && rsp_valid === 1'b0, "reset init/rsp (R1)", {init_done, rsp_valid}, 0);
    chk(mem_we_n === 1'b1 && mem_oe_n === 1'b1 && mem_dq_oe === 1'b0, "reset we/oe/dq (R3 R9)",
        {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b110);
    rst_n = 1'b1;
    begin
      int n;
      n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (!init_done && n < 1000);
      chk(n == INIT_CYC + 2, "power-up wait length (R1)", n, INIT_CYC + 2);
      chk(ce_falls == 0, "no access during wait (R1)", ce_falls, 0);
    end
    do_req(1'b1, 2'b11, 4'd3, 16'h5555, 16'h0, "held write");

    for (int v = 0; v < NVEC; v++) begin
      do_req(VEC[v][39], VEC[v][38:37], VEC[v][35:32], VEC[v][31:16], VEC[v][15:0],
             $sformatf("vec%0d", v));
    end

    // R6: wait input held high, then held low
    wait_mode = 1;
    do_req(1'b0, 2'b11, 4'd2, 16'h0, 16'h1234, "wait high (R6)");
    do_req(1'b1, 2'b01, 4'd9, 16'h00A1, 16'h0, "wait high write (R6)");
    wait_mode = 2;
    do_req(1'b0, 2'b11, 4'd9, 16'h0, 16'hC9A1, "wait low (R6)");
    wait_mode = 0;
    do_req(1'b0, 2'b00, 4'd9, 16'h0, 16'h0000, "empty read (R8)");

    repeat (4) @(negedge clk);
    chk(e_r1 == 0, "monitor R1", e_r1, 0);
    chk(e_r2 == 0, "monitor R2", e_r2, 0);
    chk(e_r3 == 0, "monitor R3", e_r3, 0);
    chk(e_r4 == 0, "monitor R4", e_r4, 0);
    chk(e_r5 == 0, "monitor R5", e_r5, 0);
    chk(max_wlen == WR_CYC && max_wlen < TCEM_CYC, "write pulse bound R7", max_wlen, WR_CYC);
    chk(e_r9 == 0, "monitor R9", e_r9, 0);
    chk(e_r10 == 0, "monitor R10", e_r10, 0);
    chk(e_r11 == 0, "monitor R11", e_r11, 0);
    chk(model[5] == 16'h77CD, "merged byte writes (R3)", model[5], 16'h77CD);
    chk(model[7] == 16'hC737, "empty write left word (R8)", model[7], 16'hC737);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule